// File: doc/BRIEF.md
# Interrupt and Halt Opcode Injection

This block sits between the external data bus and the instruction register of a small 8-bit processor core. In the opcode load slot of each fetch cycle it chooses which byte the instruction register receives. Normally that is the byte read from the bus. While the core is halted, it substitutes a no-operation code. While the core services a maskable interrupt in mode 1 or mode 2, or a non-maskable interrupt, it substitutes the single-byte restart opcode. Alongside the opcode it registers a restart target byte that the restart sequence later uses as its jump address.

The block also holds the two interrupt-enable flip-flops. The enable-interrupt, disable-interrupt and return-from-NMI strobes update them. Entry into either service state clears them. The program-counter increment hold output is raised whenever any of the three special states is active.

The fetch sequencer supplies the state inputs and the load-slot strobe. Bus timing stays outside this block.

Top module: `irq_opcode_inject`

## Requirements
- R1: Synchronous reset (rst_n low at a rising clock edge) sets opcode_out to 0x00, vec_byte to 0x00, and both iff1 and iff2 to 0.
- R2: opcode_out and vec_byte update only on a rising edge where ld_slot is 1. At every other edge they hold their value, whatever the other inputs do.
- R3: At a load edge with halted=1 and neither service input set, opcode_out becomes 0x00.
- R4: At a load edge with irq_svc=1 and nmi_svc=0, opcode_out becomes 0xFF when int_mode is 1, 2 or 3. When int_mode is 0 it becomes bus_byte unchanged. With no state input set, opcode_out becomes bus_byte.
- R5: At a load edge with nmi_svc=1, opcode_out becomes 0xFF and vec_byte becomes 0x66, whatever halted, irq_svc and int_mode are. NMI ranks above the maskable interrupt, and either service input overrides halted.
- R6: At a load edge without nmi_svc, vec_byte becomes 0x00 when a maskable interrupt is served with int_mode 2 or 3. In every other case it becomes {2'b00, new opcode bits 5:3, 3'b000}, which gives 0x38 for the injected 0xFF.
- R7: pc_hold is 1 in the same cycle that any of halted, irq_svc or nmi_svc is 1, and 0 otherwise (combinational).
- R8: A rising nmi_svc (0 at the previous edge, 1 at this one) clears iff1 and leaves iff2 unchanged.
- R9: A rising irq_svc clears both iff1 and iff2.
- R10: retn_stb copies iff2 into iff1 at the next edge.
- R11: di_ei_stb loads op_bit3 into both iff1 and iff2 at the next edge.
- R12: At an edge where either service input rises, di_ei_stb and retn_stb are ignored. di_ei_stb takes precedence over retn_stb when both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_slot | input | 1 | Opcode load slot strobe |
| halted | input | 1 | Core is in halt state |
| irq_svc | input | 1 | Maskable interrupt service state |
| nmi_svc | input | 1 | Non-maskable interrupt service state |
| int_mode | input | 2 | Interrupt mode: 0, 1, or 2 (3 treated as 2) |
| bus_byte | input | 8 | Byte read from the external data bus |
| op_bit3 | input | 1 | Bit 3 of the current opcode (1 = enable) |
| di_ei_stb | input | 1 | Disable/enable-interrupt strobe |
| retn_stb | input | 1 | Return-from-NMI strobe |
| opcode_out | output | 8 | Byte delivered to the instruction register |
| vec_byte | output | 8 | Restart target byte |
| pc_hold | output | 1 | Suppress program-counter increment |
| iff1 | output | 1 | Interrupt enable flip-flop 1 |
| iff2 | output | 1 | Interrupt enable flip-flop 2 |

## Verification
The bench sweeps every combination of the three state inputs and the four mode codes against several bus bytes. This catches a priority inverted between NMI and the maskable interrupt, which would show 0x38 in place of 0x66. It also catches halt winning over a service state, which would inject 0x00, and a mode-0 interrupt that forces 0xFF when it should pass the bus byte through. Interleaved non-load edges expose an opcode register that updates without the strobe. The flip-flop sequences check that NMI entry leaves iff2 untouched, so a design that cleared both would lose the state RETN restores. A strobe that arrives in the same cycle as service entry must not win, or the core would come out of entry with interrupts enabled.

// File: rtl/iinj_pkg.sv
// Shared types for the opcode injection block.
// Assumes an 8-bit or wider opcode path.
package iinj_pkg;
    // Which special state governs the current load slot, highest priority last.
    typedef enum logic [1:0] {
        SVC_NONE = 2'd0,
        SVC_HALT = 2'd1,
        SVC_IRQ  = 2'd2,
        SVC_NMI  = 2'd3
    } svc_t;
endpackage

// File: rtl/iinj_arbiter.sv
// Resolves the three service-state inputs to one governing state.
// NMI ranks above the maskable interrupt, and both rank above halt.
// Assumes the inputs are stable levels from the fetch sequencer.
module iinj_arbiter
    import iinj_pkg::*;
(
    input  logic halted,
    input  logic irq_svc,
    input  logic nmi_svc,
    output svc_t svc,
    output logic any_state
);
    // Fixed-priority pick of the governing state.
    always_comb begin
        if (nmi_svc)      svc = SVC_NMI;
        else if (irq_svc) svc = SVC_IRQ;
        else if (halted)  svc = SVC_HALT;
        else              svc = SVC_NONE;
    end

    // The PC holds in any special state.
    always_comb any_state = halted | irq_svc | nmi_svc;
endmodule

// File: rtl/iinj_byte_mux.sv
// Chooses the opcode byte and the restart target for one load slot.
// Assumes DW >= 6 so that the restart field (bits 5:3) exists.
module iinj_byte_mux
    import iinj_pkg::*;
#(
    parameter int DW        = 8,
    parameter int NOP_CODE  = 'h00,
    parameter int RST_CODE  = 'hFF,
    parameter int NMI_VEC   = 'h66
) (
    input  svc_t          svc,
    input  logic [1:0]    int_mode,
    input  logic [DW-1:0] bus_byte,
    output logic [DW-1:0] op_next,
    output logic [DW-1:0] vec_next
);
    localparam logic [DW-1:0] NOP_B = DW'(NOP_CODE);
    localparam logic [DW-1:0] RST_B = DW'(RST_CODE);
    localparam logic [DW-1:0] NMI_B = DW'(NMI_VEC);
    localparam int            PADH  = DW - 6;

    logic mode0;
    logic vec_table;

    // Mode decode: 0 passes the bus byte; 2 and 3 fetch the target from a table.
    always_comb begin
        mode0     = (int_mode == 2'd0);
        vec_table = (svc == SVC_IRQ) && int_mode[1];
    end

    // Opcode substitution by governing state.
    always_comb begin
        unique case (svc)
            SVC_NMI:  op_next = RST_B;
            SVC_IRQ:  op_next = mode0 ? bus_byte : RST_B;
            SVC_HALT: op_next = NOP_B;
            default:  op_next = bus_byte;
        endcase
    end

    // Restart target: fixed for NMI, none for table mode, else opcode field 5:3.
    always_comb begin
        if (svc == SVC_NMI)  vec_next = NMI_B;
        else if (vec_table)  vec_next = '0;
        else                 vec_next = {{PADH{1'b0}}, 2'b00, op_next[5:3], 3'b000};
    end
endmodule

// File: rtl/iinj_iff.sv
// Interrupt-enable flip-flop pair with service-entry edge detection.
// Entry edges outrank strobes in the same cycle; DI/EI outranks RETN.
// Assumes the strobes are single-cycle pulses.
module iinj_iff (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_svc,
    input  logic nmi_svc,
    input  logic op_bit3,
    input  logic di_ei_stb,
    input  logic retn_stb,
    output logic iff1,
    output logic iff2
);
    logic irq_prev, nmi_prev;
    logic irq_rise, nmi_rise;

    // Remember last cycle's service levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_prev <= 1'b0;
            nmi_prev <= 1'b0;
        end else begin
            irq_prev <= irq_svc;
            nmi_prev <= nmi_svc;
        end
    end

    // Entry edges.
    always_comb begin
        irq_rise = irq_svc & ~irq_prev;
        nmi_rise = nmi_svc & ~nmi_prev;
    end

    // Flip-flop update with entry clearing first, then strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (irq_rise || nmi_rise) begin
            iff1 <= 1'b0;
            if (irq_rise) iff2 <= 1'b0;
        end else if (di_ei_stb) begin
            iff1 <= op_bit3;
            iff2 <= op_bit3;
        end else if (retn_stb) begin
            iff1 <= iff2;
        end
    end
endmodule

// File: rtl/irq_opcode_inject.sv
// Top of the opcode injection block: arbitration, byte selection, the
// load-slot registers for opcode and target, and the enable flip-flops.
// Assumes ld_slot marks exactly the edge where the instruction register loads.
module irq_opcode_inject
    import iinj_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_slot,
    input  logic          halted,
    input  logic          irq_svc,
    input  logic          nmi_svc,
    input  logic [1:0]    int_mode,
    input  logic [DW-1:0] bus_byte,
    input  logic          op_bit3,
    input  logic          di_ei_stb,
    input  logic          retn_stb,
    output logic [DW-1:0] opcode_out,
    output logic [DW-1:0] vec_byte,
    output logic          pc_hold,
    output logic          iff1,
    output logic          iff2
);
    svc_t          svc;
    logic [DW-1:0] op_next;
    logic [DW-1:0] vec_next;

    iinj_arbiter u_arb (
        .halted    (halted),
        .irq_svc   (irq_svc),
        .nmi_svc   (nmi_svc),
        .svc       (svc),
        .any_state (pc_hold)
    );

    iinj_byte_mux #(.DW(DW)) u_mux (
        .svc      (svc),
        .int_mode (int_mode),
        .bus_byte (bus_byte),
        .op_next  (op_next),
        .vec_next (vec_next)
    );

    iinj_iff u_iff (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_svc   (irq_svc),
        .nmi_svc   (nmi_svc),
        .op_bit3   (op_bit3),
        .di_ei_stb (di_ei_stb),
        .retn_stb  (retn_stb),
        .iff1      (iff1),
        .iff2      (iff2)
    );

    // Capture the chosen opcode and target in the load slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_out <= '0;
            vec_byte   <= '0;
        end else if (ld_slot) begin
            opcode_out <= op_next;
            vec_byte   <= vec_next;
        end
    end
endmodule

// File: rtl/irq_opcode_inject_chk.sv
// Property checker for irq_opcode_inject, bound to every instance.
// Keeps its own copy of the service levels for edge detection.
module irq_opcode_inject_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_slot,
    input logic          halted,
    input logic          irq_svc,
    input logic          nmi_svc,
    input logic          di_ei_stb,
    input logic          retn_stb,
    input logic          op_bit3,
    input logic [DW-1:0] opcode_out,
    input logic [DW-1:0] vec_byte,
    input logic          pc_hold,
    input logic          iff1,
    input logic          iff2
);
    logic c_irq_q, c_nmi_q;

    // Previous service levels, seen independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_irq_q <= 1'b0;
            c_nmi_q <= 1'b0;
        end else begin
            c_irq_q <= irq_svc;
            c_nmi_q <= nmi_svc;
        end
    end

    a_r2_hold_without_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_slot |=> $stable(opcode_out) && $stable(vec_byte));

    a_r3_halt_nop: assert property (@(posedge clk) disable iff (!rst_n)
        ld_slot && halted && !irq_svc && !nmi_svc |=> opcode_out == '0);

    a_r5_nmi_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ld_slot && nmi_svc |=> opcode_out == DW'('hFF) && vec_byte == DW'('h66));

    a_r7_hold_in_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_svc || irq_svc || halted) |-> pc_hold);

    a_r9_irq_clears_both: assert property (@(posedge clk) disable iff (!rst_n)
        irq_svc && !c_irq_q |=> !iff1 && !iff2);

    a_r8_nmi_keeps_iff2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_svc && !c_nmi_q && !(irq_svc && !c_irq_q) |=> !iff1 && iff2 == $past(iff2));

    a_r10_retn_copy: assert property (@(posedge clk) disable iff (!rst_n)
        retn_stb && !di_ei_stb && !(irq_svc && !c_irq_q) && !(nmi_svc && !c_nmi_q)
        |=> iff1 == $past(iff2));

    a_r11_di_ei_load: assert property (@(posedge clk) disable iff (!rst_n)
        di_ei_stb && !(irq_svc && !c_irq_q) && !(nmi_svc && !c_nmi_q)
        |=> iff1 == $past(op_bit3) && iff2 == $past(op_bit3));
endmodule

bind irq_opcode_inject irq_opcode_inject_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_slot    (ld_slot),
    .halted     (halted),
    .irq_svc    (irq_svc),
    .nmi_svc    (nmi_svc),
    .di_ei_stb  (di_ei_stb),
    .retn_stb   (retn_stb),
    .op_bit3    (op_bit3),
    .opcode_out (opcode_out),
    .vec_byte   (vec_byte),
    .pc_hold    (pc_hold),
    .iff1       (iff1),
    .iff2       (iff2)
);

// File: tb/sim_irq_opcode_inject.sv
module sim_irq_opcode_inject;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ld_slot, halted, irq_svc, nmi_svc;
    logic [1:0] int_mode;
    logic [7:0] bus_byte;
    logic       op_bit3, di_ei_stb, retn_stb;
    logic [7:0] opcode_out, vec_byte;
    logic       pc_hold, iff1, iff2;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_opcode_inject u0 (
        .clk(clk), .rst_n(rst_n), .ld_slot(ld_slot), .halted(halted),
        .irq_svc(irq_svc), .nmi_svc(nmi_svc), .int_mode(int_mode),
        .bus_byte(bus_byte), .op_bit3(op_bit3), .di_ei_stb(di_ei_stb),
        .retn_stb(retn_stb), .opcode_out(opcode_out), .vec_byte(vec_byte),
        .pc_hold(pc_hold), .iff1(iff1), .iff2(iff2)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        ld_slot = 0; halted = 0; irq_svc = 0; nmi_svc = 0; int_mode = 0;
        bus_byte = 8'h00; op_bit3 = 0; di_ei_stb = 0; retn_stb = 0;
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    initial begin : watchdog
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] bytes [4];
        logic [7:0] eop, evec, prev_op, prev_vec;
        bytes[0] = 8'h00; bytes[1] = 8'h5A; bytes[2] = 8'hC7; bytes[3] = 8'hA9;

        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 opcode", opcode_out, 8'h00);
        chk("R1 vec", vec_byte, 8'h00);
        chk("R1 iff1", iff1, 0);
        chk("R1 iff2", iff2, 0);

        // R2..R7 sweep
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int b = 0; b < 4; b++) begin
                    halted = s[0]; irq_svc = s[1]; nmi_svc = s[2];
                    int_mode = 2'(m); bus_byte = bytes[b]; ld_slot = 1;
                    #0;
                    chk("R7 pc_hold", pc_hold, (s != 0) ? 1 : 0);
                    if (s[2])                 eop = 8'hFF;
                    else if (s[1])            eop = (m == 0) ? bytes[b] : 8'hFF;
                    else if (s[0])            eop = 8'h00;
                    else                      eop = bytes[b];
                    if (s[2])                 evec = 8'h66;
                    else if (s[1] && m >= 2)  evec = 8'h00;
                    else                      evec = {2'b00, eop[5:3], 3'b000};
                    step();
                    if (s[2])      chk("R5 opcode", opcode_out, eop);
                    else if (s[1]) chk("R4 opcode", opcode_out, eop);
                    else if (s[0]) chk("R3 opcode", opcode_out, eop);
                    else           chk("R4 passthrough", opcode_out, eop);
                    if (s[2]) chk("R5 vec", vec_byte, evec);
                    else      chk("R6 vec", vec_byte, evec);
                    // R2: no load slot -> hold despite changed inputs
                    prev_op = opcode_out; prev_vec = vec_byte;
                    ld_slot = 0; bus_byte = ~bytes[b];
                    halted = ~s[0]; irq_svc = ~s[1]; nmi_svc = ~s[2];
                    step();
                    chk("R2 opcode hold", opcode_out, prev_op);
                    chk("R2 vec hold", vec_byte, prev_vec);
                end
            end
        end

        // Flip-flop sequences
        do_reset();
        op_bit3 = 1; di_ei_stb = 1; step(); di_ei_stb = 0;
        chk("R11 EI iff1", iff1, 1); chk("R11 EI iff2", iff2, 1);
        irq_svc = 1; step();
        chk("R9 irq iff1", iff1, 0); chk("R9 irq iff2", iff2, 0);
        irq_svc = 0; step();
        op_bit3 = 1; di_ei_stb = 1; step(); di_ei_stb = 0;
        nmi_svc = 1; step();
        chk("R8 nmi iff1", iff1, 0); chk("R8 nmi iff2", iff2, 1);
        nmi_svc = 0; retn_stb = 1; step(); retn_stb = 0;
        chk("R10 retn iff1", iff1, 1); chk("R10 retn iff2", iff2, 1);
        op_bit3 = 0; di_ei_stb = 1; step(); di_ei_stb = 0;
        chk("R11 DI iff1", iff1, 0); chk("R11 DI iff2", iff2, 0);
        // R12: EI in the same cycle as NMI entry is ignored
        op_bit3 = 1; di_ei_stb = 1; nmi_svc = 1; step(); di_ei_stb = 0;
        chk("R12 entry beats EI iff1", iff1, 0);
        chk("R12 entry beats EI iff2", iff2, 0);
        nmi_svc = 0; step();
        // R12: DI/EI outranks RETN (iff2=0, EI with RETN -> both 1)
        op_bit3 = 1; di_ei_stb = 1; retn_stb = 1; step();
        di_ei_stb = 0; retn_stb = 0;
        chk("R12 EI over RETN iff1", iff1, 1);
        chk("R12 EI over RETN iff2", iff2, 1);
        // R12: RETN ignored at IRQ entry
        irq_svc = 1; retn_stb = 1; step(); retn_stb = 0;
        chk("R12 entry beats RETN iff1", iff1, 0);
        irq_svc = 0; step();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule